// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block serves the move-to and move-from special-purpose register operations of a small RISC core. The core presents one request per cycle: a read or write flag, a 16-bit register address and, for writes, a 32-bit value. The core also supplies two privilege bits taken from its status word. The unit checks the privilege bits, checks the address range and checks a per-address whitelist. It then updates the system registers it owns or returns read data one cycle later.

Some addresses have side effects. Writing the status register always sets its fixed-one bit. Writing the next-PC address stores nothing and instead pulses a redirect to the core, which also cancels any pending delay slot. The timer-mode address accepts only a zero. Every rejected access raises a one-cycle warning pulse. The unit holds the status, floating-point control, exception PC, exception status and multiply-accumulate low/high registers, along with a shadow window of general registers. The version, unit-present and CPU-configuration words are constants.

Top module: `spr_access_unit`

## Requirements
- R1: An access made while both `priv_sup` and `priv_user_spr` are low is refused. A read returns 0, a write changes nothing, and `warn` pulses. Either bit alone is enough to grant access.
- R2: Any address at or above `SPR_COUNT` (default 0x6000) is refused. A read returns 0, a write is dropped, and `warn` pulses.
- R3: A permitted read sets `rd_valid` and `rd_data` in the cycle after the request. Constants: 0x0000 reads 0x12000001, 0x0001 reads 0x00000001, 0x0002 reads 0x00000020. Address 0x0012 returns `prev_pc`. Address 0x0011 returns the status register.
- R4: Reads of the exception-status register (0x0040), the next-PC address (0x0010), the timer-mode address (0x5000) and any unlisted in-range address return 0 and pulse `warn`.
- R5: Writes to 0x0014 (FP control), 0x0020 (exception PC), 0x0040 (exception status), 0x2801 (MAC low) and 0x2802 (MAC high) are stored without a warning. The exception PC and exception status registers also appear on `epcr0_out` and `esr0_out`.
- R6: Addresses 0x0400 to 0x05FF form a 512-word general-register window that can be both read and written. Address 0x0600 is unlisted.
- R7: A write to 0x0011 stores the value with bit 15 forced to 1. The status register resets to 0x00008001.
- R8: A write to 0x0010 stores nothing. In the next cycle it pulses `redirect_valid` and `delay_slot_cancel` for one cycle, with `redirect_pc` equal to the written value.
- R9: A write of zero to 0x5000 is accepted silently. A nonzero write there pulses `warn`. Neither case stores anything or redirects.
- R10: Writes to read-only or unlisted addresses (the constants, 0x0012) pulse `warn` and leave the read values unchanged.
- R11: After reset, `rd_valid`, `warn`, `redirect_valid` and `delay_slot_cancel` are low, `esr0_out` and `epcr0_out` are 0, and `sr_out` is 0x00008001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register address (group 15:11, index 10:0) |
| req_wdata | input | 32 | Write value |
| priv_sup | input | 1 | Supervisor privilege bit |
| priv_user_spr | input | 1 | User register-access permission bit |
| prev_pc | input | 32 | Previous-PC value returned for address 0x0012 |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| warn | output | 1 | Refused or bad access pulse |
| redirect_valid | output | 1 | PC redirect pulse |
| redirect_pc | output | 32 | Redirect target |
| delay_slot_cancel | output | 1 | Drop any pending delay slot |
| sr_out | output | 32 | Current status register |
| esr0_out | output | 32 | Current exception status register |
| epcr0_out | output | 32 | Current exception PC register |

## Verification
The bench aims at the edges of the whitelists. It checks that the exception-status register can be written but not read, and that the next-PC and timer-mode addresses are not readable. A design that shares one list for reads and writes would return stored data or suppress the warning in these cases. It checks the last window word 0x05FF against 0x0600, where an off-by-one would either alias or reject a valid word, and it checks 0x6000 against the range limit. It also checks that a write to the status register with bit 15 clear still reads back with that bit set, that a nonzero timer-mode write warns while a zero write does not, and that a refused write leaves the old register contents intact.

// File: rtl/spr_pkg.sv
package spr_pkg;
  typedef enum logic [3:0] {
    ID_NONE, ID_VER, ID_UNITS, ID_CFG, ID_NPC, ID_SR, ID_PPC, ID_FPC,
    ID_EPC, ID_ESR, ID_MACLO, ID_MACHI, ID_TICK, ID_GPR
  } spr_id_e;

  localparam logic [15:0] A_VER   = 16'h0000;
  localparam logic [15:0] A_UNITS = 16'h0001;
  localparam logic [15:0] A_CFG   = 16'h0002;
  localparam logic [15:0] A_NPC   = 16'h0010;
  localparam logic [15:0] A_SR    = 16'h0011;
  localparam logic [15:0] A_PPC   = 16'h0012;
  localparam logic [15:0] A_FPC   = 16'h0014;
  localparam logic [15:0] A_EPC   = 16'h0020;
  localparam logic [15:0] A_ESR   = 16'h0040;
  localparam logic [15:0] A_MACLO = 16'h2801;
  localparam logic [15:0] A_MACHI = 16'h2802;
  localparam logic [15:0] A_TICK  = 16'h5000;

  localparam int SR_FIXED_ONE_BIT = 15;
  localparam logic [31:0] SR_RESET = 32'h0000_8001;
endpackage

// File: rtl/spr_addr_decode.sv
module spr_addr_decode
  import spr_pkg::*;
#(
  parameter int SPR_COUNT = 24576,
  parameter int GPR_BASE  = 1024,
  parameter int GPR_DEPTH = 512,
  localparam int IDX_W    = $clog2(GPR_DEPTH)
) (
  input  logic [15:0]      addr,
  output spr_id_e          id,
  output logic [IDX_W-1:0] gpr_idx
);
  localparam logic [16:0] LIMIT = 17'(SPR_COUNT);
  localparam logic [16:0] G_LO  = 17'(GPR_BASE);
  localparam logic [16:0] G_HI  = 17'(GPR_BASE + GPR_DEPTH);

  always_comb begin
    gpr_idx = IDX_W'(addr - 16'(GPR_BASE));
    id = ID_NONE;
    if ({1'b0, addr} < LIMIT) begin
      if ({1'b0, addr} >= G_LO && {1'b0, addr} < G_HI) id = ID_GPR;
      else begin
        unique case (addr)
          A_VER:   id = ID_VER;
          A_UNITS: id = ID_UNITS;
          A_CFG:   id = ID_CFG;
          A_NPC:   id = ID_NPC;
          A_SR:    id = ID_SR;
          A_PPC:   id = ID_PPC;
          A_FPC:   id = ID_FPC;
          A_EPC:   id = ID_EPC;
          A_ESR:   id = ID_ESR;
          A_MACLO: id = ID_MACLO;
          A_MACHI: id = ID_MACHI;
          A_TICK:  id = ID_TICK;
          default: id = ID_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spr_gpr_window.sv
module spr_gpr_window #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/spr_sys_regs.sv
module spr_sys_regs
  import spr_pkg::*;
#(
  parameter logic [31:0] VER_WORD   = 32'h1200_0001,
  parameter logic [31:0] UNITS_WORD = 32'h0000_0001,
  parameter logic [31:0] CFG_WORD   = 32'h0000_0020
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  spr_id_e     wr_id,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  spr_id_e     rd_id,
  input  logic [31:0] prev_pc,
  output logic [31:0] rd_q,
  output logic [31:0] sr_q,
  output logic [31:0] esr_q,
  output logic [31:0] epc_q
);
  logic [31:0] fpc_q, maclo_q, machi_q;
  logic [31:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= SR_RESET;
      esr_q <= '0;
      epc_q <= '0;
      fpc_q <= '0;
      maclo_q <= '0;
      machi_q <= '0;
    end else if (wr_en) begin
      unique case (wr_id)
        ID_SR: begin
          sr_q <= wr_data;
          sr_q[SR_FIXED_ONE_BIT] <= 1'b1;
        end
        ID_ESR:   esr_q <= wr_data;
        ID_EPC:   epc_q <= wr_data;
        ID_FPC:   fpc_q <= wr_data;
        ID_MACLO: maclo_q <= wr_data;
        ID_MACHI: machi_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (rd_id)
      ID_VER:   rd_mux = VER_WORD;
      ID_UNITS: rd_mux = UNITS_WORD;
      ID_CFG:   rd_mux = CFG_WORD;
      ID_SR:    rd_mux = sr_q;
      ID_PPC:   rd_mux = prev_pc;
      ID_FPC:   rd_mux = fpc_q;
      ID_EPC:   rd_mux = epc_q;
      ID_MACLO: rd_mux = maclo_q;
      ID_MACHI: rd_mux = machi_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else rd_q <= rd_en ? rd_mux : '0;
  end

  assert_fixed_one_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_id == ID_SR) |=> sr_q[SR_FIXED_ONE_BIT]);
  assert_esr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_id == ID_ESR) |=> $stable(esr_q));
endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
  import spr_pkg::*;
#(
  parameter int SPR_COUNT = 24576,
  parameter int GPR_BASE  = 1024,
  parameter int GPR_DEPTH = 512
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic        priv_sup,
  input  logic        priv_user_spr,
  input  logic [31:0] prev_pc,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        warn,
  output logic        redirect_valid,
  output logic [31:0] redirect_pc,
  output logic        delay_slot_cancel,
  output logic [31:0] sr_out,
  output logic [31:0] esr0_out,
  output logic [31:0] epcr0_out
);
  localparam int IDX_W = $clog2(GPR_DEPTH);

  spr_id_e          id;
  logic [IDX_W-1:0] gidx;
  logic allowed, readable, write_ok, rd_req, wr_req, bad;
  logic gpr_sel_q;
  logic [31:0] sys_rd, gpr_rd;

  spr_addr_decode #(.SPR_COUNT(SPR_COUNT), .GPR_BASE(GPR_BASE), .GPR_DEPTH(GPR_DEPTH))
    u_dec (.addr(req_addr), .id(id), .gpr_idx(gidx));

  always_comb begin
    allowed = priv_sup | priv_user_spr;
    unique case (id)
      ID_VER, ID_UNITS, ID_CFG, ID_SR, ID_PPC, ID_FPC, ID_EPC,
      ID_MACLO, ID_MACHI, ID_GPR: readable = 1'b1;
      default: readable = 1'b0;
    endcase
    unique case (id)
      ID_FPC, ID_EPC, ID_ESR, ID_MACLO, ID_MACHI, ID_GPR,
      ID_SR, ID_NPC: write_ok = 1'b1;
      ID_TICK: write_ok = (req_wdata == '0);
      default: write_ok = 1'b0;
    endcase
    rd_req = req_valid & ~req_write & allowed & readable;
    wr_req = req_valid & req_write & allowed & write_ok;
    bad    = req_valid & ~(req_write ? (allowed & write_ok) : (allowed & readable));
  end

  spr_sys_regs u_sys (
    .clk(clk), .rst(rst),
    .wr_en(wr_req), .wr_id(id), .wr_data(req_wdata),
    .rd_en(rd_req && id != ID_GPR), .rd_id(id), .prev_pc(prev_pc),
    .rd_q(sys_rd), .sr_q(sr_out), .esr_q(esr0_out), .epc_q(epcr0_out)
  );

  spr_gpr_window #(.DEPTH(GPR_DEPTH), .DATA_W(32)) u_gpr (
    .clk(clk),
    .we(wr_req && id == ID_GPR), .waddr(gidx), .wdata(req_wdata),
    .re(rd_req && id == ID_GPR), .raddr(gidx), .rdata(gpr_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      gpr_sel_q <= 1'b0;
      warn <= 1'b0;
      redirect_valid <= 1'b0;
      redirect_pc <= '0;
      delay_slot_cancel <= 1'b0;
    end else begin
      rd_valid <= req_valid & ~req_write;
      gpr_sel_q <= rd_req && id == ID_GPR;
      warn <= bad;
      redirect_valid <= wr_req && id == ID_NPC;
      delay_slot_cancel <= wr_req && id == ID_NPC;
      if (wr_req && id == ID_NPC) redirect_pc <= req_wdata;
    end
  end

  assign rd_data = !rd_valid ? '0 : (gpr_sel_q ? gpr_rd : sys_rd);

  assert_no_priv_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !priv_sup && !priv_user_spr) |=> (warn && rd_data == '0 && !redirect_valid));
  assert_out_of_range_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && {1'b0, req_addr} >= 17'(SPR_COUNT)) |=> (warn && rd_data == '0));
  assert_read_latency_R3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(req_valid && !req_write));
  assert_npc_redirect_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && (priv_sup || priv_user_spr) && req_addr == A_NPC)
    |=> (redirect_valid && delay_slot_cancel && redirect_pc == $past(req_wdata)));
  assert_tick_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && (priv_sup || priv_user_spr) && req_addr == A_TICK)
    |=> (!redirect_valid && warn == ($past(req_wdata) != 32'h0)));
endmodule

// File: tb/spr_access_unit_tb.sv
`timescale 1ns/1ps
module spr_access_unit_tb;
  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, priv_sup = 1, priv_user_spr = 0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0, prev_pc = 32'hCAFE_0000;
  logic rd_valid, warn, redirect_valid, delay_slot_cancel;
  logic [31:0] rd_data, redirect_pc, sr_out, esr0_out, epcr0_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spr_access_unit u_dut (.*);

  // vector: [81] write, [80:65] addr, [64:33] wdata, [32:1] expected read, [0] expected warn
  localparam int NV = 30;
  localparam logic [81:0] VECS [NV] = '{
    {1'b0, 16'h0000, 32'h0, 32'h1200_0001, 1'b0},  // R3 version word
    {1'b0, 16'h0001, 32'h0, 32'h0000_0001, 1'b0},  // R3 units word
    {1'b0, 16'h0002, 32'h0, 32'h0000_0020, 1'b0},  // R3 config word
    {1'b0, 16'h0011, 32'h0, 32'h0000_8001, 1'b0},  // R3 status reset value
    {1'b0, 16'h0012, 32'h0, 32'hCAFE_0000, 1'b0},  // R3 previous pc
    {1'b1, 16'h0014, 32'h0000_0A5A, 32'h0, 1'b0},  // R5 fp control write
    {1'b0, 16'h0014, 32'h0, 32'h0000_0A5A, 1'b0},  // R5
    {1'b1, 16'h0020, 32'h1000_0040, 32'h0, 1'b0},  // R5 exception pc
    {1'b0, 16'h0020, 32'h0, 32'h1000_0040, 1'b0},  // R5
    {1'b1, 16'h2801, 32'h1111_2222, 32'h0, 1'b0},  // R5 mac low
    {1'b1, 16'h2802, 32'h3333_4444, 32'h0, 1'b0},  // R5 mac high
    {1'b0, 16'h2801, 32'h0, 32'h1111_2222, 1'b0},  // R5
    {1'b0, 16'h2802, 32'h0, 32'h3333_4444, 1'b0},  // R5
    {1'b1, 16'h0400, 32'hDEAD_0001, 32'h0, 1'b0},  // R6 first window word
    {1'b1, 16'h05FF, 32'hDEAD_01FF, 32'h0, 1'b0},  // R6 last window word
    {1'b0, 16'h0400, 32'h0, 32'hDEAD_0001, 1'b0},  // R6
    {1'b0, 16'h05FF, 32'h0, 32'hDEAD_01FF, 1'b0},  // R6
    {1'b0, 16'h0600, 32'h0, 32'h0, 1'b1},          // R6 past window
    {1'b1, 16'h0600, 32'h5, 32'h0, 1'b1},          // R6
    {1'b0, 16'h0040, 32'h0, 32'h0, 1'b1},          // R4 exception status unreadable
    {1'b0, 16'h0010, 32'h0, 32'h0, 1'b1},          // R4 next pc unreadable
    {1'b0, 16'h5000, 32'h0, 32'h0, 1'b1},          // R4 timer mode unreadable
    {1'b1, 16'h5000, 32'h0, 32'h0, 1'b0},          // R9 zero write silent
    {1'b1, 16'h5000, 32'h5, 32'h0, 1'b1},          // R9 nonzero write warns
    {1'b1, 16'h0000, 32'h7, 32'h0, 1'b1},          // R10 write to constant
    {1'b0, 16'h0000, 32'h0, 32'h1200_0001, 1'b0},  // R10 constant unchanged
    {1'b0, 16'h6000, 32'h0, 32'h0, 1'b1},          // R2 first out-of-range
    {1'b1, 16'hFFFF, 32'h9, 32'h0, 1'b1},          // R2
    {1'b0, 16'h0003, 32'h0, 32'h0, 1'b1},          // R4 unlisted address
    {1'b1, 16'h0012, 32'h1, 32'h0, 1'b1}           // R10 previous pc read-only
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request; outputs sampled at the following falling edge
  task automatic req(input logic wr, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check("R11 rd_valid", 32'(rd_valid), 0);
    check("R11 warn", 32'(warn), 0);
    check("R11 redirect", 32'(redirect_valid), 0);
    check("R11 cancel", 32'(delay_slot_cancel), 0);
    check("R11 sr_out", sr_out, 32'h0000_8001);
    check("R11 esr0_out", esr0_out, 0);
    check("R11 epcr0_out", epcr0_out, 0);

    for (int i = 0; i < NV; i++) begin
      logic [81:0] v;
      v = VECS[i];
      req(v[81], v[80:65], v[64:33]);
      $sformat(tag_buf, "vec%0d addr=%h warn", i, v[80:65]);
      check(tag_buf, 32'(warn), 32'(v[0]));
      check("vec rd_valid R3", 32'(rd_valid), 32'(!v[81]));
      if (!v[81]) check("vec rd_data R3", rd_data, v[32:1]);
      check("vec no redirect R8", 32'(redirect_valid), 0);
    end

    // R7 status write forces bit 15
    req(1, 16'h0011, 32'h0000_0003);
    check("R7 sr_out", sr_out, 32'h0000_8003);
    check("R7 warn", 32'(warn), 0);
    req(0, 16'h0011, 0);
    check("R7 readback", rd_data, 32'h0000_8003);

    // R5 exception status write visible on its output
    req(1, 16'h0040, 32'h0000_0077);
    check("R5 esr0_out", esr0_out, 32'h0000_0077);
    check("R5 epcr0_out", epcr0_out, 32'h1000_0040);

    // R8 next-pc write
    req(1, 16'h0010, 32'h0000_2000);
    check("R8 redirect_valid", 32'(redirect_valid), 1);
    check("R8 redirect_pc", redirect_pc, 32'h0000_2000);
    check("R8 cancel", 32'(delay_slot_cancel), 1);
    check("R8 warn", 32'(warn), 0);
    @(negedge clk);
    check("R8 pulse ends", 32'(redirect_valid), 0);
    check("R8 cancel ends", 32'(delay_slot_cancel), 0);

    // R1 privilege gating
    priv_sup = 0; priv_user_spr = 0;
    req(0, 16'h0014, 0);
    check("R1 read data", rd_data, 0);
    check("R1 read warn", 32'(warn), 1);
    req(1, 16'h0014, 32'h0000_0001);
    check("R1 write warn", 32'(warn), 1);
    req(1, 16'h0010, 32'h0000_4000);
    check("R1 no redirect", 32'(redirect_valid), 0);
    priv_user_spr = 1;
    req(0, 16'h0014, 0);
    check("R1 user bit grants read", rd_data, 32'h0000_0A5A);
    check("R1 user bit no warn", 32'(warn), 0);
    priv_sup = 1; priv_user_spr = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  string tag_buf;
endmodule